// File: doc/BRIEF.md
# Skewed-Carry Synchronous Ripple Counter

This block is a wide free-running up counter for logic fabrics that offer no dedicated carry chain. It is a chain of synchronous divide-by-two stages on a common clock. Each stage hands its carry to the next stage as a one-cycle pulse held in a register. As a result, no combinational path crosses more than one stage. The logic in front of any flip-flop is a single 2:1 select (toggle or hold), or a single gate for a carry register. This holds at any width, including 32 bits and more.

There is a cost to this structure. Bit k of the output lags the ideal binary bit k by exactly k clock cycles, so the raw word is not a plain binary number while carries are still in flight. When counting pauses for WIDTH-1 cycles, every pending carry drains and the raw word equals the true count modulo 2^WIDTH. A consumer can either wait for that to happen or apply the skew correction itself.

Top module: `skew_ripple_counter`

## Requirements
- R1: When `rst` is high at a clock edge, `raw_word` becomes all zeros and every pending stage carry is discarded. With `cnt_en` then held low, `raw_word` stays zero.
- R2: Bit 0 of `raw_word` inverts at each edge where `cnt_en` is high and `rst` is low, and it holds its value when `cnt_en` is low.
- R3: Let n(t) be the number of enabled edges since the last reset, taken modulo 2^WIDTH, with n = 0 at and before that reset. After edge t, bit k of `raw_word` equals bit k of n(t-k).
- R4: Carries already in flight keep propagating after `cnt_en` goes low. After WIDTH-1 further edges with `cnt_en` low, `raw_word` equals n modulo 2^WIDTH.
- R5: For k ≥ 1, bit k changes at an edge exactly when bit k-1 went from 1 to 0 at the previous edge, provided neither edge was a reset.
- R6: The carry from stage k to stage k+1 is a registered pulse one cycle wide. It is raised only after an edge where stage k fell from 1 to 0, and it is never high on two consecutive cycles.
- R7: The count wraps modulo 2^WIDTH. After 2^WIDTH enabled edges from reset and a WIDTH-1 cycle drain, `raw_word` is zero again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all stages |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable for stage 0 |
| raw_word | output | WIDTH | Skewed stage word; bit k lags the binary count by k cycles |

## Verification
The hardest situation to reach is a long carry that ripples through every stage while the enable drops or a reset arrives. In that case several one-cycle pulses are in flight at different heights of the chain. The bench runs the count up to values just below powers of two, including the full wrap, and then stops enabling or resets on the very next cycle. Random enable patterns with sparse resets are added on top of these directed cases. A per-cycle model of the delayed count compares every bit on every cycle.

// File: rtl/skewcnt_pkg.sv
package skewcnt_pkg;

  // Next state of a divide-by-two stage: the only logic in front of the bit
  // flop is a 2:1 select between toggle and hold.
  function automatic logic stage_next(input logic cur, input logic trig);
    return trig ? ~cur : cur;
  endfunction

  // A stage emits a carry when it toggles while holding a one (a 1 -> 0 fall).
  function automatic logic carry_next(input logic cur, input logic trig);
    return trig & cur;
  endfunction

  // Number of idle cycles needed for every in-flight carry to drain.
  function automatic int unsigned drain_cycles(input int unsigned width);
    return width - 1;
  endfunction

endpackage

// File: rtl/toggle_stage.sv
module toggle_stage
  import skewcnt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic bit_q
);

  always_ff @(posedge clk) begin
    if (rst) bit_q <= 1'b0;
    else     bit_q <= stage_next(bit_q, trig);
  end

endmodule

// File: rtl/carry_pipe.sv
module carry_pipe
  import skewcnt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic src_bit,
  input  logic src_trig,
  output logic pulse_q
);

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= carry_next(src_bit, src_trig);
  end

endmodule

// File: rtl/skew_ripple_counter.sv
module skew_ripple_counter #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  output logic [WIDTH-1:0] raw_word
);

  localparam int unsigned NCARRY = WIDTH - 1;

  // Named internal events, visible to the bound checker.
  logic [WIDTH-1:0]  stage_trig;
  logic [NCARRY-1:0] carry_q;

  assign stage_trig[0] = cnt_en;

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    if (k > 0) begin : g_chain
      assign stage_trig[k] = carry_q[k-1];
    end

    toggle_stage u_bit (
      .clk   (clk),
      .rst   (rst),
      .trig  (stage_trig[k]),
      .bit_q (raw_word[k])
    );

    if (k < NCARRY) begin : g_carry
      carry_pipe u_carry (
        .clk      (clk),
        .rst      (rst),
        .src_bit  (raw_word[k]),
        .src_trig (stage_trig[k]),
        .pulse_q  (carry_q[k])
      );
    end
  end

endmodule

// File: rtl/skew_ripple_counter_chk.sv
module skew_ripple_counter_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic [WIDTH-1:0] raw_word,
  input logic [WIDTH-2:0] carry_q
);

  // live1: the previous edge was not a reset; live2: neither of the last two.
  logic live1 = 1'b0;
  logic live2 = 1'b0;
  logic rst_d = 1'b0;

  always_ff @(posedge clk) begin
    live1 <= !rst;
    live2 <= live1 && !rst;
    rst_d <= rst;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst_d |-> (raw_word == '0 && carry_q == '0));

  assert_bit0_step_R2: assert property (@(posedge clk) disable iff (rst)
    live1 |-> (raw_word[0] == ($past(raw_word[0]) ^ $past(cnt_en))));

  assert_upper_follow_R5: assert property (@(posedge clk) disable iff (rst)
    live2 |-> ((raw_word[WIDTH-1:1] ^ $past(raw_word[WIDTH-1:1])) ==
               ($past(raw_word[WIDTH-2:0], 2) & ~$past(raw_word[WIDTH-2:0]))));

  assert_carry_source_R6: assert property (@(posedge clk) disable iff (rst)
    live1 |-> (carry_q == ($past(raw_word[WIDTH-2:0]) & ~raw_word[WIDTH-2:0])));

  assert_carry_single_R6: assert property (@(posedge clk) disable iff (rst)
    live1 |-> ((carry_q & $past(carry_q)) == '0));

endmodule

bind skew_ripple_counter skew_ripple_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cnt_en   (cnt_en),
  .raw_word (raw_word),
  .carry_q  (carry_q)
);

// File: tb/test_skew_ripple_counter.sv
module test_skew_ripple_counter;

  localparam int unsigned W    = 10;
  localparam int unsigned MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnt_en = 1'b0;
  logic [W-1:0] raw_word;

  int checks = 0;
  int errors = 0;
  int unsigned hist [W];        // hist[k] = ideal count k edges ago
  logic [W-1:0] prev1, prev2;
  int since_rst = 0;

  always #4 clk = ~clk;         // 125 MHz

  skew_ripple_counter #(.WIDTH(W)) i_skew_ripple_counter (
    .clk      (clk),
    .rst      (rst),
    .cnt_en   (cnt_en),
    .raw_word (raw_word)
  );

  function automatic logic [W-1:0] expect_word();
    logic [W-1:0] e;
    for (int k = 0; k < W; k++) e[k] = hist[k][k];
    return e;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Drive at negedge, model at posedge, compare at the next negedge.
  task automatic step(input logic en, input logic r);
    prev2 = prev1;
    prev1 = raw_word;
    cnt_en = en;
    rst = r;
    @(posedge clk);
    if (r) begin
      for (int k = 0; k < W; k++) hist[k] = 0;
      since_rst = 0;
    end else begin
      for (int k = W - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = (hist[0] + (en ? 1 : 0)) & MASK;
      since_rst++;
    end
    @(negedge clk);
    check("R3 skewed word", raw_word, expect_word());
    check("R2 bit0", {{(W-1){1'b0}}, raw_word[0]}, {{(W-1){1'b0}}, hist[0][0]});
    if (since_rst >= 2)  // R5/R6: upper bits follow the delayed carry pulse
      check("R5/R6 carry follow", {raw_word[W-1:1] ^ prev1[W-1:1], 1'b0},
            {prev2[W-2:0] & ~prev1[W-2:0], 1'b0});
  endtask

  task automatic drain_and_check(input string req);
    for (int i = 0; i < W - 1; i++) step(1'b0, 1'b0);
    check(req, raw_word, hist[0][W-1:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < W; k++) hist[k] = 0;
    prev1 = '0;
    prev2 = '0;
    @(negedge clk);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    check("R1 reset state", raw_word, '0);

    // R2: plain enabled run, then a held bit 0
    for (int i = 0; i < 37; i++) step(1'b1, 1'b0);
    drain_and_check("R4 drain after 37");
    check("R2 hold while idle", {{(W-1){1'b0}}, raw_word[0]}, {{(W-1){1'b0}}, 1'b1});

    // R4: stop right after a long carry is launched (count 511 -> 512)
    step(1'b0, 1'b1);
    for (int i = 0; i < 512; i++) step(1'b1, 1'b0);
    drain_and_check("R4 drain long carry");

    // R1: reset while a long carry is in flight, carries must vanish
    step(1'b0, 1'b1);
    for (int i = 0; i < 256; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    for (int i = 0; i < W; i++) begin
      step(1'b0, 1'b0);
      check("R1 no leftover carry", raw_word, '0);
    end

    // R7: full wrap
    for (int i = 0; i < (1 << W); i++) step(1'b1, 1'b0);
    drain_and_check("R7 wrap to zero");
    check("R7 model zero", hist[0][W-1:0], '0);

    // Random enable with sparse resets and periodic drains
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) != 0, ($urandom % 300) == 0);
      if ((i % 700) == 699) drain_and_check("R4 random drain");
    end

    report();
    $finish;
  end

endmodule